// File: doc/BRIEF.md
# Up/Down Counter with Event Interrupts

This block is an 8-bit counter that steps up or down by one on each clock where counting is enabled, with the direction chosen by a single input. One programmable register supplies two things at once: the value the counter is compared against and the value the counter is loaded with when it wraps below zero. Counting upward past the top value wraps to zero.

Four events are recorded in sticky flags: a change of the direction input, a compare hit, an overflow and an underflow. Each flag stays set until software writes 0 to its bit. Three enable bits gate the flags onto one interrupt line. Overflow and underflow share one enable. A small register port reads and writes the shared value, the flags and the enables. Reads are combinational.

Register map (`reg_addr`): 0 is the reload/compare value. 1 holds the flags: bit 0 direction change, bit 1 compare, bit 2 overflow, bit 3 underflow. 2 holds the enables: bit 0 direction change, bit 1 compare, bit 2 overflow-or-underflow. Address 3 reads as zero.

Top module: `updn_irq_unit`

## Requirements
- R1: After reset the counter, all flags and all enables read 0, the reload/compare value reads 0x00 and `irq` is 0.
- R2: With `cnt_en`=1 and `dir_down`=0 the counter rises by one per clock below 0xFF. With `cnt_en`=0 the counter holds its value.
- R3: Counting up from 0xFF loads 0x00 and sets flag bit 2 (overflow).
- R4: Counting down loads the counter with one less than its value. Counting down from 0x00 loads the reload/compare value and sets flag bit 3 (underflow).
- R5: One write to address 0 sets the value used both as compare value and as reload value, and it reads back at address 0.
- R6: Flag bit 1 (compare) is set at the clock edge where an enabled count step makes the counter equal to the reload/compare value.
- R7: Flag bit 0 (direction change) is set at a clock edge where `dir_down` differs from its value at the previous edge. It is not set while `dir_down` is steady.
- R8: Flags are sticky. Writing 0 to a bit at address 1 clears that flag, and writing 1 has no effect.
- R9: When an event and a clear of the same flag fall on the same clock edge, the flag stays set.
- R10: `irq` is 1 exactly when some flag is set whose enable at address 2 is 1: bit 0 gates the direction flag, bit 1 gates the compare flag, and bit 2 gates the overflow and underflow flags.
- R11: Overflow and underflow set separate flags, and both are passed to `irq` by the single enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Count step enable |
| dir_down | input | 1 | Count direction: 1 counts down, 0 counts up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| count | output | 8 | Current counter value |
| irq | output | 1 | Combined interrupt request |

## Verification
Counter value, flags and register contents change at the first rising edge after their input is presented. `irq` follows that same edge with no further delay, and read data follows `reg_addr` within the same cycle. The bench changes inputs on falling edges and samples one falling edge later, so each result is read half a period after the edge that should have produced it. Register reads are sampled shortly after the address settles. Reset release passes through a two-stage synchronizer, so the bench waits three cycles before its first check.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] ADR_VAL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FLG = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_ENA = 2'd2;

  localparam int NFLG    = 4;
  localparam int FLG_DIR = 0;
  localparam int FLG_CMP = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UDF = 3;

  localparam int NEN     = 3;
  localparam int EN_DIR  = 0;
  localparam int EN_CMP  = 1;
  localparam int EN_WRAP = 2;

  typedef logic [NFLG-1:0] flag_vec_t;
  typedef logic [NEN-1:0]  en_vec_t;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shift_q <= '0;
    else           shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shift_q[STAGES-1];
endmodule

// File: rtl/updn_count.sv
module updn_count
  import updn_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         dir_down,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count,
  output flag_vec_t    evt
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] count_q, cnt_nxt;
  logic         dir_q;
  logic         wrap_up, wrap_dn;

  always_comb begin
    cnt_nxt = count_q;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (cnt_en) begin
      if (!dir_down) begin
        if (count_q == MAXV) begin
          cnt_nxt = '0;
          wrap_up = 1'b1;
        end else begin
          cnt_nxt = count_q + 1'b1;
        end
      end else begin
        if (count_q == '0) begin
          cnt_nxt = cmp_val;
          wrap_dn = 1'b1;
        end else begin
          cnt_nxt = count_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    evt          = '0;
    evt[FLG_DIR] = dir_down ^ dir_q;
    evt[FLG_CMP] = cnt_en && (cnt_nxt == cmp_val);
    evt[FLG_OVF] = wrap_up;
    evt[FLG_UDF] = wrap_dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= 1'b0;
    end else begin
      dir_q <= dir_down;
      if (cnt_en) count_q <= cnt_nxt;
    end
  end

  assign count = count_q;

  // R2
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count_q));
  // R2
  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_down && count_q != MAXV) |=> (count_q == $past(count_q) + 1'b1));
  // R3
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !dir_down && count_q == MAXV) |=> (count_q == '0));
  // R4
  a_r4_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dir_down && count_q == '0) |=> (count_q == $past(cmp_val)));
  // R11
  a_r11_one_wrap_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt[FLG_OVF] && evt[FLG_UDF]));
endmodule

// File: rtl/updn_regs.sv
module updn_regs
  import updn_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  flag_vec_t         evt,
  output logic [W-1:0]      cmp_val,
  output logic              irq
);
  localparam int PAD_F = W - NFLG;
  localparam int PAD_E = W - NEN;

  logic [W-1:0] val_q;
  flag_vec_t    flg_q, flg_nxt, clr;
  en_vec_t      en_q;
  logic         wr_val, wr_ena, wr_flg;

  assign wr_val = reg_wr && (reg_addr == ADR_VAL);
  assign wr_ena = reg_wr && (reg_addr == ADR_ENA);
  assign wr_flg = reg_wr && (reg_addr == ADR_FLG);

  for (genvar i = 0; i < NFLG; i++) begin : g_flag
    assign clr[i]     = wr_flg && !reg_wdata[i];
    assign flg_nxt[i] = evt[i] | (flg_q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[i] <= 1'b0;
      else        flg_q[i] <= flg_nxt[i];
    end

    // R9
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flg_q[i]);
    // R8
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[i] && !clr[i]) |=> flg_q[i]);
    // R8
    a_r8_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!flg_q[i] && !evt[i]) |=> !flg_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_val) val_q <= reg_wdata;
      if (wr_ena) en_q  <= reg_wdata[NEN-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_VAL: reg_rdata = val_q;
      ADR_FLG: reg_rdata = {{PAD_F{1'b0}}, flg_q};
      ADR_ENA: reg_rdata = {{PAD_E{1'b0}}, en_q};
      default: reg_rdata = '0;
    endcase
  end

  assign cmp_val = val_q;
  assign irq = (flg_q[FLG_DIR] & en_q[EN_DIR])
             | (flg_q[FLG_CMP] & en_q[EN_CMP])
             | ((flg_q[FLG_OVF] | flg_q[FLG_UDF]) & en_q[EN_WRAP]);

  // R5
  a_r5_value_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> (val_q == $past(reg_wdata)));
  // R10
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0 && flg_q != '0));
endmodule

// File: rtl/updn_irq_unit.sv
module updn_irq_unit
  import updn_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              dir_down,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic [W-1:0]      count,
  output logic              irq
);
  logic         rst_n_s;
  logic [W-1:0] cmp_val;
  flag_vec_t    evt;

  updn_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  updn_count #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cnt_en  (cnt_en),
    .dir_down(dir_down),
    .cmp_val (cmp_val),
    .count   (count),
    .evt     (evt)
  );

  updn_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .evt      (evt),
    .cmp_val  (cmp_val),
    .irq      (irq)
  );
endmodule

// File: tb/sim_updn_irq_unit.sv
module sim_updn_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cnt_en, dir_down, reg_wr, irq;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, count;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cnt_en = 1'b0; dir_down = 1'b0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 count", count, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd_chk("R1 value", 2'd0, 8'h00);
    rd_chk("R1 flags", 2'd1, 8'h00);
    rd_chk("R1 enables", 2'd2, 8'h00);
  endtask

  task automatic t_value_write;
    wr(2'd0, 8'h05);
    rd_chk("R5 readback", 2'd0, 8'h05);
  endtask

  task automatic t_count_and_compare;
    run(3);
    chk("R2 up by three", count, 8'h03);
    rd_chk("R6 no early compare", 2'd1, 8'h00);
    run(2);
    chk("R6 count at compare", count, 8'h05);
    rd_chk("R6 compare flag", 2'd1, 8'h02);
    repeat (2) @(negedge clk);
    chk("R2 hold while idle", count, 8'h05);
    rd_chk("R8 flag sticky", 2'd1, 8'h02);
  endtask

  task automatic t_flag_writes;
    wr(2'd1, 8'hFF);
    rd_chk("R8 write one no effect", 2'd1, 8'h02);
    wr(2'd1, 8'hFD);
    rd_chk("R8 write zero clears", 2'd1, 8'h00);
  endtask

  task automatic t_overflow;
    wr(2'd0, 8'hF0);
    run(250);
    chk("R2 reach top", count, 8'hFF);
    rd_chk("R3 no overflow yet", 2'd1, 8'h02);
    run(1);
    chk("R3 wrap to zero", count, 8'h00);
    rd_chk("R3 overflow flag", 2'd1, 8'h06);
    chk("R10 irq off with no enables", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h04);
    chk("R11 overflow via shared enable", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    rd_chk("R8 clear all", 2'd1, 8'h00);
  endtask

  task automatic t_underflow;
    dir_down = 1'b1;
    run(1);
    chk("R4 reload on underflow", count, 8'hF0);
    rd_chk("R4 R7 R11 flags after underflow", 2'd1, 8'h0B);
    run(1);
    chk("R4 step down", count, 8'hEF);
    rd_chk("R7 steady direction", 2'd1, 8'h0B);
  endtask

  task automatic t_irq;
    chk("R10 irq off", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h04);
    chk("R11 underflow via shared enable", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'hF7);
    chk("R10 irq drops after clear", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h01);
    chk("R10 direction enable", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'hFE);
    chk("R10 direction cleared", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h02);
    chk("R10 compare enable", {7'd0, irq}, 8'h01);
    rd_chk("R10 enable readback", 2'd2, 8'h02);
    wr(2'd1, 8'h00);
    chk("R10 all cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision;
    dir_down = 1'b0;
    wr(2'd1, 8'h00);
    rd_chk("R9 event beats clear", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    repeat (2) @(negedge clk);
    rd_chk("R7 no event when steady", 2'd1, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_value_write;
    t_count_and_compare;
    t_flag_writes;
    t_overflow;
    t_underflow;
    t_irq;
    t_collision;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule